// File: doc/BRIEF.md
# Two-Wire Register-File Slave

This block is a two-wire serial slave that gives a host access to a bank of 8-bit control registers. A fast system clock oversamples SCL and SDA. The block detects START, repeated START and STOP conditions and matches its 7-bit device address. It acknowledges each byte and pulls the data line low through an open-drain enable.

Two access styles share one device address, and the command byte selects between them. A command with bit 7 set is a single-byte access to the register numbered by its low seven bits. A command with bit 7 clear starts a block access at register 0. A block write carries a byte count, then data that fills consecutive registers. A block read first returns a count byte, then register contents in ascending order.

The bank loads fixed defaults at reset. One register is a constant identifier. The low nibble of register 1 mirrors four strap pins, captured once after reset. The full read view of the bank drives a flat configuration output for the surrounding clock logic.

Top module: `smb_regfile`

## Requirements
- R1: The block acknowledges 8'hD2 as a write address and 8'hD3 as a read address (7-bit address 69h). For any other address it sends no acknowledge, and the bytes that follow until the next START change no register.
- R2: With no transfer in progress, and after every STOP, sda_oe_o is 0. The block asserts sda_oe_o only while SCL is low.
- R3: A write of {address D2h, command with bit 7 = 1, data byte} stores the data in the register numbered by command bits 6..0.
- R4: A byte read is {D2h, command with bit 7 = 1}, then a repeated START, then D3h. The block then shifts out the addressed register MSB first, and it releases SDA after the master's NACK.
- R5: A command with bit 7 = 0 (normally 00h) starts a block access at register 0. In a block write, the next byte is a count N, and the following N data bytes go to registers 0..N-1. Data bytes beyond N are acknowledged and discarded.
- R6: A block read is {D2h, 00h}, then a repeated START, then D3h. It returns the register count (22 = 16h) first, then register 0, register 1 and so on, until the master NACKs.
- R7: After reset the registers read: reg0 10h, reg1 E0h with the strap nibble in bits 3..0, reg2 FFh, reg5 00h, reg7 01h, reg20 88h and reg21 00h.
- R8: Register 1 bits 3..0 return strap_i as sampled on the first clock after reset. Writes to these bits have no effect, and later changes of strap_i have no effect.
- R9: Register 7 always reads 01h and ignores writes.
- R10: Writes to register numbers 22 and above are acknowledged and discarded. Reads of those numbers return 00h.
- R11: cfg_o carries the read view of register i in bits [8i+7:8i]. After the strap capture, it changes only through a completed data-byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| strap_i | input | 4 | Strap pins mirrored into register 1 bits 3..0 |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_o | output | 176 | Read view of all 22 registers, register i at bits [8i+7:8i] |

## Verification
The assertions assume a bus that is slow compared with the system clock. Each SCL level must last several clocks, so that every edge the synchronizer sees is separated from SDA changes and from the next SCL edge. The assertions also assume that SDA changes only while SCL is low, except when the master forms a START or STOP. The bench's master holds each SCL phase for eight system clocks. It changes its own data only after a full low-phase wait, and it releases the line before every acknowledge slot that belongs to the slave.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned IDX_W     = 7;
  localparam int unsigned STRAP_W   = 4;
  localparam int unsigned STRAP_IDX = 1;
  localparam int unsigned ID_IDX    = 7;
  localparam logic [BYTE_W-1:0] ID_VAL = 8'h01;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RX_ACK, S_TX, S_TX_ACK, S_WAIT} smb_state_e;
  typedef enum logic [1:0] {K_ADDR, K_CMD, K_CNT, K_DATA} rx_kind_e;

  function automatic logic [BYTE_W-1:0] reg_default(int unsigned i);
    case (i)
      0:       reg_default = 8'h10;
      1:       reg_default = 8'hE2;
      2, 3, 4: reg_default = 8'hFF;
      6:       reg_default = 8'h24;
      7:       reg_default = ID_VAL;
      8:       reg_default = 8'h90;
      9:       reg_default = 8'hBB;
      10:      reg_default = 8'h3B;
      11:      reg_default = 8'h0E;
      12:      reg_default = 8'h01;
      13:      reg_default = 8'h0A;
      14:      reg_default = 8'h10;
      15:      reg_default = 8'h2C;
      16:      reg_default = 8'h24;
      17:      reg_default = 8'h08;
      19:      reg_default = 8'hDB;
      20:      reg_default = 8'h88;
      default: reg_default = 8'h00;
    endcase
  endfunction

  // bits a host may change
  function automatic logic [BYTE_W-1:0] reg_wmask(int unsigned i);
    if (i == STRAP_IDX)   reg_wmask = 8'hF0;
    else if (i == ID_IDX) reg_wmask = 8'h00;
    else                  reg_wmask = 8'hFF;
  endfunction
endpackage

// File: rtl/smb_sampler.sv
module smb_sampler #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_N-1:0] scl_sh_q, sda_sh_q;
  logic scl_prev_q, sda_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh_q   <= '1;
      sda_sh_q   <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sh_q   <= {scl_sh_q[SYNC_N-2:0], scl_i};
      sda_sh_q   <= {sda_sh_q[SYNC_N-2:0], sda_i};
      scl_prev_q <= scl_sh_q[SYNC_N-1];
      sda_prev_q <= sda_sh_q[SYNC_N-1];
    end
  end

  assign scl_o      = scl_sh_q[SYNC_N-1];
  assign sda_o      = sda_sh_q[SYNC_N-1];
  assign scl_rise_o = scl_o & ~scl_prev_q;
  assign scl_fall_o = ~scl_o & scl_prev_q;
  assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
  assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;
endmodule

// File: rtl/smb_engine.sv
module smb_engine
  import smb_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int unsigned NREG     = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_oe_o
);
  localparam logic [BYTE_W-1:0] NREG_B = BYTE_W'(NREG);
  localparam logic [3:0]        LAST   = 4'd8;

  smb_state_e        state_q;
  rx_kind_e          kind_q;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] sreg_q, cnt_q, next_tx;
  logic [IDX_W-1:0]  ptr_q, wr_idx_q;
  logic [BYTE_W-1:0] wr_data_q;
  logic rd_q, block_q, send_cnt_q, ack_q, sda_oe_q, wr_en_q;

  // a block read begins with the count byte
  assign next_tx = send_cnt_q ? NREG_B : rd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      kind_q     <= K_ADDR;
      bit_cnt_q  <= '0;
      sreg_q     <= '0;
      cnt_q      <= '0;
      ptr_q      <= '0;
      wr_idx_q   <= '0;
      wr_data_q  <= '0;
      rd_q       <= 1'b0;
      block_q    <= 1'b0;
      send_cnt_q <= 1'b0;
      ack_q      <= 1'b0;
      sda_oe_q   <= 1'b0;
      wr_en_q    <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        state_q   <= S_RX;
        kind_q    <= K_ADDR;
        bit_cnt_q <= '0;
        sda_oe_q  <= 1'b0;
      end else if (stop_i) begin
        state_q  <= S_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        unique case (state_q)
          S_RX: begin
            if (scl_rise_i && bit_cnt_q != LAST) begin
              sreg_q    <= {sreg_q[BYTE_W-2:0], sda_s_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall_i && bit_cnt_q == LAST) begin
              bit_cnt_q <= '0;
              state_q   <= S_RX_ACK;
              sda_oe_q  <= 1'b1;
              unique case (kind_q)
                K_ADDR: begin
                  if (sreg_q[7:1] == DEV_ADDR) begin
                    rd_q       <= sreg_q[0];
                    send_cnt_q <= block_q;
                    kind_q     <= K_CMD;
                  end else begin
                    state_q  <= S_WAIT;
                    sda_oe_q <= 1'b0;
                  end
                end
                K_CMD: begin
                  if (sreg_q[7]) begin
                    block_q <= 1'b0;
                    ptr_q   <= sreg_q[IDX_W-1:0];
                    cnt_q   <= 8'd1;
                    kind_q  <= K_DATA;
                  end else begin
                    block_q <= 1'b1;
                    ptr_q   <= '0;
                    kind_q  <= K_CNT;
                  end
                end
                K_CNT: begin
                  cnt_q  <= sreg_q;
                  kind_q <= K_DATA;
                end
                default: begin
                  if (cnt_q != '0) begin
                    wr_en_q   <= 1'b1;
                    wr_idx_q  <= ptr_q;
                    wr_data_q <= sreg_q;
                    ptr_q     <= ptr_q + 1'b1;
                    cnt_q     <= cnt_q - 1'b1;
                  end
                end
              endcase
            end
          end
          S_RX_ACK: begin
            if (scl_fall_i) begin
              if (rd_q) begin
                state_q  <= S_TX;
                sreg_q   <= next_tx;
                sda_oe_q <= ~next_tx[7];
                if (send_cnt_q) send_cnt_q <= 1'b0;
                else            ptr_q      <= ptr_q + 1'b1;
              end else begin
                state_q  <= S_RX;
                sda_oe_q <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (scl_rise_i && bit_cnt_q != LAST) begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (bit_cnt_q == LAST) begin
                bit_cnt_q <= '0;
                sda_oe_q  <= 1'b0;
                state_q   <= S_TX_ACK;
              end else begin
                sreg_q   <= {sreg_q[BYTE_W-2:0], 1'b0};
                sda_oe_q <= ~sreg_q[6];
              end
            end
          end
          S_TX_ACK: begin
            if (scl_rise_i) begin
              ack_q <= ~sda_s_i;
            end else if (scl_fall_i) begin
              if (ack_q) begin
                state_q  <= S_TX;
                sreg_q   <= next_tx;
                sda_oe_q <= ~next_tx[7];
                if (send_cnt_q) send_cnt_q <= 1'b0;
                else            ptr_q      <= ptr_q + 1'b1;
              end else begin
                state_q <= S_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_idx_o  = ptr_q;
  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;
  assign sda_oe_o  = sda_oe_q;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
  import smb_pkg::*;
#(
  parameter int unsigned NREG = 22
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [STRAP_W-1:0]       strap_i,
  input  logic                     wr_en_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic [BYTE_W-1:0]        wr_data_i,
  input  logic [IDX_W-1:0]         rd_idx_i,
  output logic [BYTE_W-1:0]        rd_data_o,
  output logic [NREG*BYTE_W-1:0]   view_o,
  output logic                     latched_o
);
  localparam int unsigned SEL_W = $clog2(NREG);

  logic [STRAP_W-1:0] strap_q;
  logic               latched_q;
  logic [NREG-1:0][BYTE_W-1:0] view;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q   <= '0;
      latched_q <= 1'b0;
    end else if (!latched_q) begin
      strap_q   <= strap_i;
      latched_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == ID_IDX) begin : g_id
      assign view[g] = ID_VAL;
    end else begin : g_rw
      localparam logic [BYTE_W-1:0] DEF   = reg_default(g);
      localparam logic [BYTE_W-1:0] WM    = reg_wmask(g);
      localparam logic [BYTE_W-1:0] PIN_M = (g == STRAP_IDX) ? BYTE_W'({STRAP_W{1'b1}}) : '0;
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= DEF;
        else if (wr_en_i && wr_idx_i == IDX_W'(g)) q <= (q & ~WM) | (wr_data_i & WM);
      end
      assign view[g] = (q & ~PIN_M) | (BYTE_W'(strap_q) & PIN_M);
    end
  end

  assign rd_data_o = (rd_idx_i < IDX_W'(NREG)) ? view[rd_idx_i[SEL_W-1:0]] : '0;
  assign view_o    = view;
  assign latched_o = latched_q;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int unsigned NREG     = 22,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic [STRAP_W-1:0]     strap_i,
  output logic                   sda_oe_o,
  output logic [NREG*BYTE_W-1:0] cfg_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, strap_done;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [BYTE_W-1:0] wr_data, rd_data;

  smb_sampler #(.SYNC_N(SYNC_N)) u_sampler (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smb_engine #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_engine (
    .clk_i, .rst_ni, .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .rd_data_i(rd_data), .rd_idx_o(rd_idx),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .sda_oe_o
  );

  smb_regbank #(.NREG(NREG)) u_bank (
    .clk_i, .rst_ni, .strap_i, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .view_o(cfg_o), .latched_o(strap_done)
  );
endmodule

// File: rtl/smb_regfile_chk.sv
module smb_regfile_chk
  import smb_pkg::*;
#(
  parameter int unsigned NREG = 22
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   scl_s,
  input logic                   start_det,
  input logic                   stop_det,
  input logic                   sda_oe_o,
  input logic                   wr_en,
  input logic                   strap_done,
  input logic [NREG*BYTE_W-1:0] cfg_o
);
  a_r2_release_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  a_r2_pull_while_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !$past(scl_s));

  a_r2_release_while_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

  a_r3_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> !wr_en);

  a_r8_strap_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_done && $past(strap_done)) |-> $stable(cfg_o[BYTE_W*STRAP_IDX +: STRAP_W]));

  a_r11_cfg_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_done && $past(strap_done)) |-> ($stable(cfg_o) || $past(wr_en)));
endmodule

bind smb_regfile smb_regfile_chk #(.NREG(NREG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe_o(sda_oe_o), .wr_en(wr_en),
  .strap_done(strap_done), .cfg_o(cfg_o)
);

// File: tb/smb_regfile_bench.sv
module smb_regfile_bench;
  localparam int NREG = 22;
  localparam int T    = 8;
  localparam logic [3:0] STRAP = 4'hA;
  // {register, written, expected read}
  localparam logic [23:0] VEC [7] = '{
    {8'd0,  8'h5A, 8'h5A},  // R3 R4
    {8'd21, 8'hC3, 8'hC3},  // R3 R4
    {8'd1,  8'h3C, 8'h3A},  // R8 strap nibble kept
    {8'd7,  8'hFF, 8'h01},  // R9
    {8'd30, 8'h55, 8'h00},  // R10
    {8'd5,  8'hA5, 8'hA5},  // R3 R11
    {8'd127,8'h12, 8'h00}   // R10
  };

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, done = 1'b0;
  logic [3:0] strap = STRAP;
  logic sda_oe;
  logic [NREG*8-1:0] cfg;
  wire  sda_bus = m_sda & ~sda_oe;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  smb_regfile u_smb_regfile (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .strap_i(strap), .sda_oe_o(sda_oe), .cfg_o(cfg)
  );

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(T); m_scl = 1'b1; tick(T); m_sda = 1'b0; tick(T); m_scl = 1'b0; tick(T);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(T); m_scl = 1'b1; tick(T); m_sda = 1'b1; tick(T);
  endtask

  task automatic tx(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(T); m_scl = 1'b1; tick(T); m_scl = 1'b0; tick(T);
    end
    m_sda = 1'b1; tick(T); m_scl = 1'b1; tick(T/2); ack = ~sda_bus; tick(T/2);
    m_scl = 1'b0; tick(T);
  endtask

  task automatic rx(input logic ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(T); m_scl = 1'b1; tick(T/2); b[i] = sda_bus; tick(T/2); m_scl = 1'b0;
    end
    tick(T); m_sda = ~ack; tick(T); m_scl = 1'b1; tick(T); m_scl = 1'b0; tick(T); m_sda = 1'b1;
  endtask

  task automatic wr_reg(input logic [6:0] idx, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start; tx(8'hD2, a0); tx({1'b1, idx}, a1); tx(d, a2); bus_stop;
    ok = a0 & a1 & a2;
  endtask

  task automatic rd_reg(input logic [6:0] idx, output logic [7:0] d);
    logic a;
    bus_start; tx(8'hD2, a); tx({1'b1, idx}, a);
    bus_start; tx(8'hD3, a); rx(1'b0, d); bus_stop;
  endtask

  initial begin
    logic ok, a;
    logic [7:0] d;
    tick(5); rst_n = 1'b1; tick(5);
    // R2 R7 reset state
    check("R2 idle release", sda_oe, 0);
    check("R7 reg0", cfg[0 +: 8], 8'h10);
    check("R7 R8 reg1", cfg[8 +: 8], {4'hE, STRAP});
    check("R7 reg2", cfg[16 +: 8], 8'hFF);
    check("R7 reg5", cfg[40 +: 8], 8'h00);
    check("R7 R9 reg7", cfg[56 +: 8], 8'h01);
    check("R7 reg21", cfg[168 +: 8], 8'h00);
    rd_reg(7'd20, d);
    check("R4 R7 read reg20", d, 8'h88);
    // R8 later strap change ignored
    strap = 4'h5; tick(4);
    check("R8 strap frozen", cfg[8 +: 4], STRAP);

    foreach (VEC[k]) begin
      wr_reg(VEC[k][22:16], VEC[k][15:8], ok);
      check("R1 R3 R10 write acked", ok, 1);
      rd_reg(VEC[k][22:16], d);
      check("R3 R4 R8 R9 R10 readback", d, VEC[k][7:0]);
      if (VEC[k][23:16] < NREG)
        check("R11 cfg view", cfg[8*VEC[k][23:16] +: 8], VEC[k][7:0]);
    end

    // R1 foreign address: no ack, no change
    bus_start; tx(8'hA0, a);
    check("R1 foreign nack", a, 0);
    tx(8'h80, a); tx(8'hFF, a); bus_stop;
    check("R1 foreign no write", cfg[0 +: 8], 8'h5A);
    check("R2 release after stop", sda_oe, 0);

    // R5 block write, count 3, one extra byte
    bus_start; tx(8'hD2, a); tx(8'h00, a); tx(8'h03, a);
    tx(8'h11, a); tx(8'h22, a); tx(8'h33, a); tx(8'h44, a);
    check("R5 extra byte acked", a, 1);
    bus_stop;
    check("R5 blk reg0", cfg[0 +: 8], 8'h11);
    check("R5 R8 blk reg1", cfg[8 +: 8], {4'h2, STRAP});
    check("R5 blk reg2", cfg[16 +: 8], 8'h33);
    check("R5 extra discarded reg3", cfg[24 +: 8], 8'hFF);

    // R6 block read
    bus_start; tx(8'hD2, a); tx(8'h00, a); bus_start; tx(8'hD3, a);
    rx(1'b1, d); check("R6 count byte", d, 8'h16);
    rx(1'b1, d); check("R6 reg0", d, 8'h11);
    rx(1'b1, d); check("R6 reg1", d, {4'h2, STRAP});
    rx(1'b1, d); check("R6 reg2", d, 8'h33);
    rx(1'b0, d); check("R6 reg3", d, 8'hFF);
    tick(T);
    check("R4 released after nack", sda_oe, 0);
    bus_stop;
    check("R2 idle after block read", sda_oe, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R2 act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule